// File: doc/BRIEF.md
# Configurable CPLD Macrocell

This block is one logic cell of a programmable logic array, modelled on a fast system clock. It takes five product-term levels from the array, a sum arriving from the previous cell and a set of global signals: three clocks, a clear and two output enables. It also takes a pin level that can be stored and a second pin level that can serve as an enable. Static configuration inputs decide the rest. They choose which terms feed the OR gate and what the XOR polarity stage combines with the sum. They choose how the storage bit behaves (D, T, JK, SR or a latch that passes data while its clock is high) and where its clock, clock enable, clear and preset come from. They also choose whether the pin and the buried feedback take the stored or the combinational value, and what drives the pin output enable.

The global clocks and any product-term clock are treated as levels sampled on `clk`. The cell detects a rising edge of the selected clock level from one `clk` cycle to the next, so a cell clock may run at up to half the system rate. Clear and preset act at once on the registered outputs and take effect on the stored bit at the next `clk` edge. This matches the asynchronous behaviour of the cell they stand for. The cascade output carries the OR sum forward to the next cell. A separate output carries the inverted copy of one product term for use by neighbouring cells.

Top module: `cpld_macrocell`

## Requirements
- R1: `cas_o` equals `cas_i` OR'ed with every `pt_i[k]` whose `cfg_or_mask[k]` is 1.
- R2: The combinational value is the OR sum XOR a second operand picked by `cfg_xor_sel`: 0 gives constant 0, 1 gives constant 1, 2 gives the product term indexed by `cfg_xor_pt`, and 3 gives the stored bit as it stood after the last `clk` edge. With `cfg_out_reg`=0 it appears on `pin_o` in the same cycle.
- R3: Each product-term index input (`cfg_xor_pt`, `cfg_d_pt`, `cfg_k_pt`, `cfg_clk_pt`, `cfg_ce_pt`, `cfg_ar_pt`, `cfg_ap_pt`, `cfg_oe_pt`, `cfg_fold_pt`) selects `pt_i[idx]` for values 0 to 4 and a constant 0 for values 5 to 7.
- R4: The storage data comes from `cfg_d_src`: 0 takes the combinational XOR value, 1 takes the product term indexed by `cfg_d_pt`, and 2 or 3 takes `pin_i`.
- R5: `cfg_ff_mode` sets the update rule on a taken clock edge. 0 is D. 1 is T, which toggles when the data is 1. 2 is JK, with J as the data and K as the term indexed by `cfg_k_pt`. 3 is SR, with S as the data and R as that same term, and R wins when both are 1. Values 4 to 7 select latch mode.
- R6: `cfg_clk_sel` 0 to 2 picks `gclk_i[n]` and 3 picks the term indexed by `cfg_clk_pt`. A clock edge is taken in the `clk` cycle in which the selected level is 1 after being 0 in the previous cycle. With `cfg_out_reg`=1 the new value shows on `pin_o` from the following cycle on.
- R7: With `cfg_ce_en`=1 and a global clock selected, an edge is ignored while the term indexed by `cfg_ce_pt` is 0. With a product-term clock the enable has no effect.
- R8: In latch mode, while the selected clock level is 1 (and the enable of R7 allows it), the registered `pin_o` follows the data in the same cycle. While the level is 0 it holds the last value passed.
- R9: Clear is chosen by `cfg_ar_mode` bits: bit 0 enables `gclr_i` and bit 1 enables the term indexed by `cfg_ar_pt`. Preset is `cfg_ap_en` AND the term indexed by `cfg_ap_pt`. Either one forces the registered outputs in the same cycle and the stored bit at the next edge. Clear beats preset, and both beat any clock edge.
- R10: `cfg_out_reg` selects the registered (1) or combinational (0) value for `pin_o`. `cfg_fb_reg` makes the same choice for `fb_o`, independently of `cfg_out_reg`.
- R11: `oe_o` follows `cfg_oe_sel`: 0 always 1, 1 always 0, 2 `goe_i[0]`, 3 `goe_i[1]`, 4 `oe_pin_i`, 5 the term indexed by `cfg_oe_pt`, and 6 or 7 always 0.
- R12: `fold_o` is the inverse of the term indexed by `cfg_fold_pt`.
- R13: While `rst_n` is 0 at a `clk` edge, the stored bit and the clock-edge history are cleared. Without preset, a registered `pin_o` then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_i | input | 5 | Product-term levels |
| cas_i | input | 1 | Cascade sum from previous cell |
| gclk_i | input | 3 | Global clock levels |
| gclr_i | input | 1 | Global clear |
| goe_i | input | 2 | Global output enables |
| pin_i | input | 1 | Pin level usable as storage data |
| oe_pin_i | input | 1 | Pin level usable as output enable |
| cfg_or_mask | input | 5 | Terms routed into the OR sum |
| cfg_xor_sel | input | 2 | Second XOR operand select |
| cfg_xor_pt | input | 3 | Term index for XOR operand |
| cfg_d_src | input | 2 | Storage data source |
| cfg_d_pt | input | 3 | Term index for storage data |
| cfg_ff_mode | input | 3 | Storage behaviour |
| cfg_k_pt | input | 3 | Term index for K / R input |
| cfg_clk_sel | input | 2 | Clock source |
| cfg_clk_pt | input | 3 | Term index for term clock |
| cfg_ce_en | input | 1 | Clock enable in use |
| cfg_ce_pt | input | 3 | Term index for clock enable |
| cfg_ar_mode | input | 2 | Clear source bits |
| cfg_ar_pt | input | 3 | Term index for clear |
| cfg_ap_en | input | 1 | Preset in use |
| cfg_ap_pt | input | 3 | Term index for preset |
| cfg_out_reg | input | 1 | Pin takes registered value |
| cfg_fb_reg | input | 1 | Feedback takes registered value |
| cfg_oe_sel | input | 3 | Output enable source |
| cfg_oe_pt | input | 3 | Term index for output enable |
| cfg_fold_pt | input | 3 | Term index for foldback |
| pin_o | output | 1 | Pin data |
| oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Buried feedback |
| cas_o | output | 1 | Cascade sum to next cell |
| fold_o | output | 1 | Inverted foldback term |

## Verification
The hardest case comes when a clock edge of the selected source lands in the same `clk` cycle as an active clear or preset. A clear and a preset can also be active together. The bench provokes this with long runs in which the clear terms, the global clear and the preset terms are driven often while the clock levels toggle at random. One directed cycle also holds clear, preset and an edge together. Each cycle is judged twice against a bench model: the registered outputs in that same cycle, and the stored value seen in the following cycle, where clear must win over preset and both over the edge.

// File: rtl/cpld_macrocell_pkg.sv
// Package: encodings shared by the macrocell modules.
// Assumes: configuration inputs are static while the cell is in use.
package cpld_macrocell_pkg;

    // Second XOR operand choices
    localparam logic [1:0] XOP_ZERO  = 2'd0;
    localparam logic [1:0] XOP_ONE   = 2'd1;
    localparam logic [1:0] XOP_TERM  = 2'd2;
    localparam logic [1:0] XOP_STATE = 2'd3;

    // Storage data sources
    localparam logic [1:0] DSRC_XOR  = 2'd0;
    localparam logic [1:0] DSRC_TERM = 2'd1;

    // Storage behaviours; any value at or above MODE_LAT is a latch
    localparam logic [2:0] MODE_D   = 3'd0;
    localparam logic [2:0] MODE_T   = 3'd1;
    localparam logic [2:0] MODE_JK  = 3'd2;
    localparam logic [2:0] MODE_SR  = 3'd3;
    localparam logic [2:0] MODE_LAT = 3'd4;

    // Fixed output-enable choices; global enables follow from index 2
    localparam int OE_ON     = 0;
    localparam int OE_OFF    = 1;
    localparam int OE_GBASE  = 2;

    // Positions of the term-index selectors in the top-level pick bank
    localparam int PK_XOR  = 0;
    localparam int PK_DAT  = 1;
    localparam int PK_K    = 2;
    localparam int PK_CLK  = 3;
    localparam int PK_CE   = 4;
    localparam int PK_AR   = 5;
    localparam int PK_AP   = 6;
    localparam int PK_OE   = 7;
    localparam int PK_FOLD = 8;
    localparam int PK_NUM  = 9;

endpackage

// File: rtl/mc_pt_pick.sv
// Module: mc_pt_pick
// Selects one product term by index; indices past the last term yield 0.
// Assumes: PIW is wide enough to hold NPT-1.
module mc_pt_pick #(
    parameter int NPT = 5,
    parameter int PIW = 3
) (
    input  logic [NPT-1:0] pt_i,
    input  logic [PIW-1:0] idx_i,
    output logic           bit_o
);

    // Indexed term pick with an out-of-range default of 0
    always_comb begin
        bit_o = 1'b0;
        for (int k = 0; k < NPT; k++) begin
            if (idx_i == PIW'(k)) begin
                bit_o = pt_i[k];
            end
        end
    end

endmodule

// File: rtl/mc_sum.sv
// Module: mc_sum
// Builds the OR sum of the routed terms plus cascade-in, then the XOR stage.
// Assumes: state_i is the stored bit from the last clk edge (no loop).
module mc_sum #(
    parameter int NPT = 5
) (
    input  logic [NPT-1:0] pt_i,
    input  logic [NPT-1:0] or_mask_i,
    input  logic           cas_i,
    input  logic [1:0]     xor_sel_i,
    input  logic           xor_term_i,
    input  logic           state_i,
    output logic           or_sum_o,
    output logic           xor_o
);
    import cpld_macrocell_pkg::*;

    logic xop;

    // Sum of the routed terms and the incoming cascade
    always_comb begin
        or_sum_o = cas_i | (|(pt_i & or_mask_i));
    end

    // Polarity / arithmetic operand and XOR result
    always_comb begin
        unique case (xor_sel_i)
            XOP_ZERO:  xop = 1'b0;
            XOP_ONE:   xop = 1'b1;
            XOP_TERM:  xop = xor_term_i;
            default:   xop = state_i;
        endcase
        xor_o = or_sum_o ^ xop;
    end

endmodule

// File: rtl/mc_store.sv
// Module: mc_store
// Storage element: D/T/JK/SR on a detected rising edge of the selected
// clock level, or a latch transparent while that level is high.
// Clear and preset override the output at once and the state at the edge.
// Assumes: clock sources are levels sampled on clk, at most half its rate.
module mc_store #(
    parameter int NGCK = 3,
    parameter int CSW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGCK-1:0] gclk_i,
    input  logic [CSW-1:0]  clk_sel_i,
    input  logic            clk_term_i,
    input  logic            ce_en_i,
    input  logic            ce_term_i,
    input  logic [2:0]      mode_i,
    input  logic            d_i,
    input  logic            k_i,
    input  logic            clr_i,
    input  logic            pre_i,
    output logic            q_o,
    output logic            state_o
);
    import cpld_macrocell_pkg::*;

    logic ck_lvl;
    logic ck_prev;
    logic use_gck;
    logic enable;
    logic is_latch;
    logic edge_hit;
    logic open_gate;
    logic q_r;
    logic q_nxt;

    // Selected clock level: a global clock or the term clock
    always_comb begin
        ck_lvl = clk_term_i;
        for (int g = 0; g < NGCK; g++) begin
            if (clk_sel_i == CSW'(g)) begin
                ck_lvl = gclk_i[g];
            end
        end
    end

    // Clock enable applies only when a global clock is in use
    always_comb begin
        use_gck   = (clk_sel_i < CSW'(NGCK));
        enable    = !(ce_en_i && use_gck) || ce_term_i;
        is_latch  = (mode_i >= MODE_LAT);
        edge_hit  = ck_lvl && !ck_prev && enable;
        open_gate = ck_lvl && enable;
    end

    // Update rule for an edge-triggered element
    always_comb begin
        unique case (mode_i)
            MODE_D:  q_nxt = d_i;
            MODE_T:  q_nxt = q_r ^ d_i;
            MODE_JK: q_nxt = (d_i && !q_r) || (!k_i && q_r);
            MODE_SR: q_nxt = k_i ? 1'b0 : (d_i ? 1'b1 : q_r);
            default: q_nxt = d_i;
        endcase
    end

    // State and edge-history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r     <= 1'b0;
            ck_prev <= 1'b0;
        end else begin
            ck_prev <= ck_lvl;
            if (clr_i) begin
                q_r <= 1'b0;
            end else if (pre_i) begin
                q_r <= 1'b1;
            end else if (is_latch) begin
                if (open_gate) begin
                    q_r <= d_i;
                end
            end else if (edge_hit) begin
                q_r <= q_nxt;
            end
        end
    end

    // Visible value: overrides first, then latch flow-through
    always_comb begin
        if (clr_i) begin
            q_o = 1'b0;
        end else if (pre_i) begin
            q_o = 1'b1;
        end else if (is_latch && open_gate) begin
            q_o = d_i;
        end else begin
            q_o = q_r;
        end
        state_o = q_r;
    end

endmodule

// File: rtl/mc_route.sv
// Module: mc_route
// Output and feedback selection, output-enable source and foldback term.
// Assumes: OEW holds every fixed and global enable code.
module mc_route #(
    parameter int NGOE = 2,
    parameter int OEW  = 3
) (
    input  logic            out_reg_i,
    input  logic            fb_reg_i,
    input  logic            q_i,
    input  logic            comb_i,
    input  logic [OEW-1:0]  oe_sel_i,
    input  logic [NGOE-1:0] goe_i,
    input  logic            oe_pin_i,
    input  logic            oe_term_i,
    input  logic            fold_term_i,
    output logic            pin_o,
    output logic            fb_o,
    output logic            oe_o,
    output logic            fold_o
);
    import cpld_macrocell_pkg::*;

    localparam int OE_PIN  = OE_GBASE + NGOE;
    localparam int OE_TERM = OE_PIN + 1;

    // Pin and buried feedback each choose registered or combinational
    always_comb begin
        pin_o  = out_reg_i ? q_i : comb_i;
        fb_o   = fb_reg_i  ? q_i : comb_i;
        fold_o = !fold_term_i;
    end

    // Output-enable multiplexer; unused codes disable the driver
    always_comb begin
        oe_o = 1'b0;
        if (oe_sel_i == OEW'(OE_ON)) begin
            oe_o = 1'b1;
        end
        for (int g = 0; g < NGOE; g++) begin
            if (oe_sel_i == OEW'(OE_GBASE + g)) begin
                oe_o = goe_i[g];
            end
        end
        if (oe_sel_i == OEW'(OE_PIN)) begin
            oe_o = oe_pin_i;
        end
        if (oe_sel_i == OEW'(OE_TERM)) begin
            oe_o = oe_term_i;
        end
    end

endmodule

// File: rtl/cpld_macrocell.sv
// Module: cpld_macrocell (top)
// One configurable logic cell: OR/XOR sum, storage element, output,
// feedback, output-enable and foldback selection.
// Assumes: cfg_* inputs are static configuration; clocks are sampled levels.
module cpld_macrocell #(
    parameter int NPT  = 5,
    parameter int NGCK = 3,
    parameter int NGOE = 2,
    localparam int PIW = $clog2(NPT + 1),
    localparam int CSW = $clog2(NGCK + 1),
    localparam int OEW = $clog2(NGOE + 4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPT-1:0]  pt_i,
    input  logic            cas_i,
    input  logic [NGCK-1:0] gclk_i,
    input  logic            gclr_i,
    input  logic [NGOE-1:0] goe_i,
    input  logic            pin_i,
    input  logic            oe_pin_i,
    input  logic [NPT-1:0]  cfg_or_mask,
    input  logic [1:0]      cfg_xor_sel,
    input  logic [PIW-1:0]  cfg_xor_pt,
    input  logic [1:0]      cfg_d_src,
    input  logic [PIW-1:0]  cfg_d_pt,
    input  logic [2:0]      cfg_ff_mode,
    input  logic [PIW-1:0]  cfg_k_pt,
    input  logic [CSW-1:0]  cfg_clk_sel,
    input  logic [PIW-1:0]  cfg_clk_pt,
    input  logic            cfg_ce_en,
    input  logic [PIW-1:0]  cfg_ce_pt,
    input  logic [1:0]      cfg_ar_mode,
    input  logic [PIW-1:0]  cfg_ar_pt,
    input  logic            cfg_ap_en,
    input  logic [PIW-1:0]  cfg_ap_pt,
    input  logic            cfg_out_reg,
    input  logic            cfg_fb_reg,
    input  logic [OEW-1:0]  cfg_oe_sel,
    input  logic [PIW-1:0]  cfg_oe_pt,
    input  logic [PIW-1:0]  cfg_fold_pt,
    output logic            pin_o,
    output logic            oe_o,
    output logic            fb_o,
    output logic            cas_o,
    output logic            fold_o
);
    import cpld_macrocell_pkg::*;

    logic [PIW-1:0]    pick_idx [PK_NUM];
    logic [PK_NUM-1:0] pick_bit;
    logic              or_sum;
    logic              xor_val;
    logic              state;
    logic              q_vis;
    logic              d_val;
    logic              clr;
    logic              pre;

    // Gather the term indices into one bank
    always_comb begin
        pick_idx[PK_XOR]  = cfg_xor_pt;
        pick_idx[PK_DAT]  = cfg_d_pt;
        pick_idx[PK_K]    = cfg_k_pt;
        pick_idx[PK_CLK]  = cfg_clk_pt;
        pick_idx[PK_CE]   = cfg_ce_pt;
        pick_idx[PK_AR]   = cfg_ar_pt;
        pick_idx[PK_AP]   = cfg_ap_pt;
        pick_idx[PK_OE]   = cfg_oe_pt;
        pick_idx[PK_FOLD] = cfg_fold_pt;
    end

    // One term picker per configurable use
    for (genvar s = 0; s < PK_NUM; s++) begin : g_pick
        mc_pt_pick #(.NPT(NPT), .PIW(PIW)) u_pick (
            .pt_i  (pt_i),
            .idx_i (pick_idx[s]),
            .bit_o (pick_bit[s])
        );
    end

    mc_sum #(.NPT(NPT)) u_sum (
        .pt_i       (pt_i),
        .or_mask_i  (cfg_or_mask),
        .cas_i      (cas_i),
        .xor_sel_i  (cfg_xor_sel),
        .xor_term_i (pick_bit[PK_XOR]),
        .state_i    (state),
        .or_sum_o   (or_sum),
        .xor_o      (xor_val)
    );

    // Storage data source and clear / preset combination
    always_comb begin
        unique case (cfg_d_src)
            DSRC_XOR:  d_val = xor_val;
            DSRC_TERM: d_val = pick_bit[PK_DAT];
            default:   d_val = pin_i;
        endcase
        clr = (cfg_ar_mode[0] && gclr_i) || (cfg_ar_mode[1] && pick_bit[PK_AR]);
        pre = cfg_ap_en && pick_bit[PK_AP];
    end

    mc_store #(.NGCK(NGCK), .CSW(CSW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .gclk_i     (gclk_i),
        .clk_sel_i  (cfg_clk_sel),
        .clk_term_i (pick_bit[PK_CLK]),
        .ce_en_i    (cfg_ce_en),
        .ce_term_i  (pick_bit[PK_CE]),
        .mode_i     (cfg_ff_mode),
        .d_i        (d_val),
        .k_i        (pick_bit[PK_K]),
        .clr_i      (clr),
        .pre_i      (pre),
        .q_o        (q_vis),
        .state_o    (state)
    );

    mc_route #(.NGOE(NGOE), .OEW(OEW)) u_route (
        .out_reg_i   (cfg_out_reg),
        .fb_reg_i    (cfg_fb_reg),
        .q_i         (q_vis),
        .comb_i      (xor_val),
        .oe_sel_i    (cfg_oe_sel),
        .goe_i       (goe_i),
        .oe_pin_i    (oe_pin_i),
        .oe_term_i   (pick_bit[PK_OE]),
        .fold_term_i (pick_bit[PK_FOLD]),
        .pin_o       (pin_o),
        .fb_o        (fb_o),
        .oe_o        (oe_o),
        .fold_o      (fold_o)
    );

    // Cascade carries the OR sum forward
    always_comb begin
        cas_o = or_sum;
    end

endmodule

// File: rtl/cpld_macrocell_chk.sv
// Module: cpld_macrocell_chk
// Port-level properties of the macrocell, bound into every instance.
// Assumes: the same parameters as the bound top.
module cpld_macrocell_chk #(
    parameter int NPT  = 5,
    parameter int NGCK = 3,
    parameter int NGOE = 2,
    localparam int PIW = $clog2(NPT + 1),
    localparam int CSW = $clog2(NGCK + 1),
    localparam int OEW = $clog2(NGOE + 4)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPT-1:0]  pt_i,
    input logic            cas_i,
    input logic [NGCK-1:0] gclk_i,
    input logic            gclr_i,
    input logic [NPT-1:0]  cfg_or_mask,
    input logic [2:0]      cfg_ff_mode,
    input logic [CSW-1:0]  cfg_clk_sel,
    input logic [1:0]      cfg_ar_mode,
    input logic            cfg_ap_en,
    input logic            cfg_out_reg,
    input logic            cfg_fb_reg,
    input logic [OEW-1:0]  cfg_oe_sel,
    input logic [PIW-1:0]  cfg_fold_pt,
    input logic            pin_o,
    input logic            oe_o,
    input logic            fb_o,
    input logic            cas_o,
    input logic            fold_o
);

    // R1
    cascade_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_or_mask == '0) |-> (cas_o == cas_i));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ar_mode[0] && gclr_i && cfg_out_reg) |-> !pin_o);

    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_sel == OEW'(1)) |-> !oe_o);

    // R12
    fold_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fold_pt == '0) |-> (fold_o == !pt_i[0]));

    // R10
    same_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_reg && cfg_fb_reg) |-> (pin_o == fb_o));

    // R6
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ff_mode == 3'd0 && cfg_clk_sel == '0 && !gclk_i[0] &&
         cfg_ar_mode == 2'd0 && !cfg_ap_en && cfg_out_reg)
        |=> (!$stable(cfg_ff_mode) || !$stable(cfg_out_reg) ||
             cfg_ar_mode != 2'd0 || cfg_ap_en || $stable(pin_o)));

endmodule

bind cpld_macrocell cpld_macrocell_chk #(.NPT(NPT), .NGCK(NGCK), .NGOE(NGOE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pt_i        (pt_i),
    .cas_i       (cas_i),
    .gclk_i      (gclk_i),
    .gclr_i      (gclr_i),
    .cfg_or_mask (cfg_or_mask),
    .cfg_ff_mode (cfg_ff_mode),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_ar_mode (cfg_ar_mode),
    .cfg_ap_en   (cfg_ap_en),
    .cfg_out_reg (cfg_out_reg),
    .cfg_fb_reg  (cfg_fb_reg),
    .cfg_oe_sel  (cfg_oe_sel),
    .cfg_fold_pt (cfg_fold_pt),
    .pin_o       (pin_o),
    .oe_o        (oe_o),
    .fb_o        (fb_o),
    .cas_o       (cas_o),
    .fold_o      (fold_o)
);

// File: tb/tb_cpld_macrocell.sv
`timescale 1ns/1ps
module tb_cpld_macrocell;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] pt_i;
    logic       cas_i;
    logic [2:0] gclk_i;
    logic       gclr_i;
    logic [1:0] goe_i;
    logic       pin_i;
    logic       oe_pin_i;
    logic [4:0] cfg_or_mask;
    logic [1:0] cfg_xor_sel;
    logic [2:0] cfg_xor_pt;
    logic [1:0] cfg_d_src;
    logic [2:0] cfg_d_pt;
    logic [2:0] cfg_ff_mode;
    logic [2:0] cfg_k_pt;
    logic [1:0] cfg_clk_sel;
    logic [2:0] cfg_clk_pt;
    logic       cfg_ce_en;
    logic [2:0] cfg_ce_pt;
    logic [1:0] cfg_ar_mode;
    logic [2:0] cfg_ar_pt;
    logic       cfg_ap_en;
    logic [2:0] cfg_ap_pt;
    logic       cfg_out_reg;
    logic       cfg_fb_reg;
    logic [2:0] cfg_oe_sel;
    logic [2:0] cfg_oe_pt;
    logic [2:0] cfg_fold_pt;
    logic       pin_o, oe_o, fb_o, cas_o, fold_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic m_q  = 1'b0;
    logic m_ck = 1'b0;
    logic [31:0] rs = 32'h1234_5678;

    cpld_macrocell dut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    // Term pick per R3: 0..4 index the terms, 5..7 give 0
    function automatic logic pick(input logic [2:0] idx);
        return (idx < 3'd5) ? pt_i[idx] : 1'b0;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    task automatic rand_cfg();
        rs = xs(rs);
        cfg_or_mask = rs[4:0];   cfg_xor_sel = rs[6:5];   cfg_xor_pt = rs[9:7];
        cfg_d_src   = rs[11:10]; cfg_d_pt    = rs[14:12]; cfg_ff_mode = rs[17:15];
        cfg_k_pt    = rs[20:18]; cfg_clk_sel = rs[22:21]; cfg_clk_pt = rs[25:23];
        cfg_ce_en   = rs[26];    cfg_ce_pt   = rs[29:27];
        cfg_out_reg = rs[30];    cfg_fb_reg  = rs[31];
        rs = xs(rs);
        cfg_ar_mode = rs[1:0] & {2{rs[19] & rs[20]}};
        cfg_ar_pt   = rs[4:2];   cfg_ap_en   = rs[5] & rs[6]; cfg_ap_pt = rs[9:7];
        cfg_oe_sel  = rs[12:10]; cfg_oe_pt   = rs[15:13];     cfg_fold_pt = rs[18:16];
    endtask

    task automatic rand_in();
        rs = xs(rs);
        pt_i   = rs[4:0];  cas_i = rs[5] & rs[6]; gclk_i = rs[9:7];
        gclr_i = rs[10] & rs[11] & rs[12];        goe_i  = rs[14:13];
        pin_i  = rs[15];   oe_pin_i = rs[16];
    endtask

    // One clk cycle: compare outputs with the model, then advance the model
    task automatic cyc(input string tag, input bit do_chk);
        logic orsum, xop, xo, d, lvl, en, ar, ap, lat, kb, qe, nx, nq, eoe;
        #1;
        orsum = cas_i | (|(pt_i & cfg_or_mask));
        case (cfg_xor_sel)
            2'd0: xop = 1'b0;
            2'd1: xop = 1'b1;
            2'd2: xop = pick(cfg_xor_pt);
            default: xop = m_q;
        endcase
        xo  = orsum ^ xop;
        d   = (cfg_d_src == 2'd0) ? xo : (cfg_d_src == 2'd1) ? pick(cfg_d_pt) : pin_i;
        lvl = (cfg_clk_sel == 2'd3) ? pick(cfg_clk_pt) : gclk_i[cfg_clk_sel];
        en  = (cfg_ce_en && cfg_clk_sel != 2'd3) ? pick(cfg_ce_pt) : 1'b1;
        ar  = (cfg_ar_mode[0] & gclr_i) | (cfg_ar_mode[1] & pick(cfg_ar_pt));
        ap  = cfg_ap_en & pick(cfg_ap_pt);
        lat = (cfg_ff_mode >= 3'd4);
        kb  = pick(cfg_k_pt);
        qe  = ar ? 1'b0 : ap ? 1'b1 : (lat && lvl && en) ? d : m_q;
        case (cfg_oe_sel)
            3'd0: eoe = 1'b1;
            3'd2: eoe = goe_i[0];
            3'd3: eoe = goe_i[1];
            3'd4: eoe = oe_pin_i;
            3'd5: eoe = pick(cfg_oe_pt);
            default: eoe = 1'b0;
        endcase
        if (do_chk) begin
            chk(tag,   pin_o,  cfg_out_reg ? qe : xo);
            chk("R10", fb_o,   cfg_fb_reg  ? qe : xo);
            chk("R1",  cas_o,  orsum);
            chk("R11", oe_o,   eoe);
            chk("R12", fold_o, !pick(cfg_fold_pt));
        end
        case (cfg_ff_mode)
            3'd0: nx = d;
            3'd1: nx = m_q ^ d;
            3'd2: nx = (d & !m_q) | (!kb & m_q);
            3'd3: nx = kb ? 1'b0 : (d ? 1'b1 : m_q);
            default: nx = d;
        endcase
        if (!rst_n)   nq = 1'b0;
        else if (ar)  nq = 1'b0;
        else if (ap)  nq = 1'b1;
        else if (lat) nq = (lvl && en) ? d : m_q;
        else          nq = (lvl && !m_ck && en) ? nx : m_q;
        @(posedge clk);
        m_q  = nq;
        m_ck = rst_n ? lvl : 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R13 watchdog expired: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pt_i = '0; cas_i = 0; gclk_i = '0; gclr_i = 0; goe_i = '0; pin_i = 0; oe_pin_i = 0;
        cfg_or_mask = '0; cfg_xor_sel = '0; cfg_xor_pt = '0; cfg_d_src = '0;
        cfg_d_pt = '0; cfg_ff_mode = '0; cfg_k_pt = '0; cfg_clk_sel = '0;
        cfg_clk_pt = '0; cfg_ce_en = 0; cfg_ce_pt = '0; cfg_ar_mode = '0;
        cfg_ar_pt = '0; cfg_ap_en = 0; cfg_ap_pt = '0; cfg_out_reg = 1;
        cfg_fb_reg = 1; cfg_oe_sel = '0; cfg_oe_pt = '0; cfg_fold_pt = '0;
        @(negedge clk);
        cyc("R13", 0);
        cyc("R13", 1);   // R13: reset state, registered pin reads 0
        rst_n = 1'b1;
        cyc("R13", 1);

        // R1 / R2: full sweep of routing mask, terms, cascade and XOR operand
        cfg_out_reg = 0; cfg_fb_reg = 0; cfg_xor_pt = 3'd1;
        for (int m = 0; m < 32; m++)
            for (int p = 0; p < 32; p++)
                for (int c = 0; c < 2; c++)
                    for (int x = 0; x < 3; x++) begin
                        cfg_or_mask = 5'(m); pt_i = 5'(p); cas_i = c[0]; cfg_xor_sel = 2'(x);
                        cyc("R2", 1);
                    end

        // R3: every index value, including the out-of-range ones
        cfg_or_mask = '0; cas_i = 0; cfg_xor_sel = 2'd2;
        for (int i = 0; i < 8; i++)
            for (int p = 0; p < 32; p++) begin
                cfg_xor_pt = 3'(i); cfg_fold_pt = 3'(i); cfg_oe_sel = 3'd5; cfg_oe_pt = 3'(i);
                pt_i = 5'(p);
                cyc("R3", 1);
            end

        // R4: data source sweep with a toggling global clock in D mode
        cfg_out_reg = 1; cfg_ff_mode = 3'd0; cfg_clk_sel = 2'd0; cfg_ce_en = 0;
        cfg_ar_mode = 2'd0; cfg_ap_en = 0;
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 24; k++) begin
                rand_in(); cfg_d_src = 2'(s); gclk_i[0] = k[0];
                cyc("R4", 1);
            end

        // R6: each clock source, pin data, random levels
        cfg_d_src = 2'd2; cfg_clk_pt = 3'd4;
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 32; k++) begin
                rand_in(); cfg_clk_sel = 2'(s);
                cyc("R6", 1);
            end

        // R7: clock enable with global and term clocks
        for (int n = 0; n < 40; n++) begin
            rand_cfg(); cfg_ce_en = 1; cfg_ar_mode = 2'd0; cfg_ap_en = 0; cfg_out_reg = 1;
            for (int k = 0; k < 16; k++) begin rand_in(); cyc("R7", 1); end
        end

        // R8: latch mode
        for (int n = 0; n < 40; n++) begin
            rand_cfg(); cfg_ff_mode = 3'd4 | 3'(n % 4); cfg_ar_mode = 2'd0;
            cfg_ap_en = 0; cfg_out_reg = 1;
            for (int k = 0; k < 16; k++) begin rand_in(); cyc("R8", 1); end
        end

        // R9: clear and preset together, with clock edges in the same cycle
        for (int n = 0; n < 60; n++) begin
            rand_cfg(); cfg_ar_mode = 2'(1 + n % 3); cfg_ap_en = 1; cfg_out_reg = 1;
            for (int k = 0; k < 16; k++) begin
                rand_in(); rs = xs(rs); gclr_i = rs[3];
                cyc("R9", 1);
            end
        end
        cfg_ar_mode = 2'd1; gclr_i = 1; cfg_ap_en = 1; cfg_ap_pt = 3'd0;
        pt_i = 5'b11111; cfg_ff_mode = 3'd0; cfg_clk_sel = 2'd0; gclk_i = 3'b001;
        cfg_d_src = 2'd2; pin_i = 1; m_ck = m_ck;
        cyc("R9", 1);    // clear, preset and data 1 at once: pin reads 0
        gclr_i = 0; gclk_i = 3'b000;
        cyc("R9", 1);    // stored bit cleared, preset now drives 1

        // R10: independent pin and feedback views
        for (int n = 0; n < 40; n++) begin
            rand_cfg();
            for (int k = 0; k < 16; k++) begin rand_in(); cyc("R10", 1); end
        end

        // R5 and R13: broad random configurations with a mid-run reset
        for (int n = 0; n < 300; n++) begin
            rand_cfg();
            for (int k = 0; k < 30; k++) begin
                rand_in();
                rst_n = !(n == 150 && k < 2);
                cyc((rst_n ? "R5" : "R13"), 1);
            end
        end
        rst_n = 1'b1;

        done = 1;
        summary();
        $finish;
    end

endmodule